// File: doc/BRIEF.md
# Cache-Miss Ray Parking Buffer

This block sits between a ray pipeline stage and that stage's data cache. Each incoming ray arrives with its cache verdict (hit or miss) and the block address it touched. A ray that hit passes straight through to the pipeline in the same cycle. A ray that missed is parked in one of a small set of rows, and each row is tagged with the missed block address. Only the first miss on an address creates a row and a memory request. Later misses on the same address join that row and add no traffic.

When the memory system returns a fill for a tagged address, the row releases its parked ray IDs back into the pipeline, one per cycle and in the order they arrived. During the fetch, other rays, both hits and misses on other blocks, keep flowing.

Ray-in, ray-out and the memory request port are valid/ready streams. A sender holds valid and its payload steady until ready is seen on a rising edge. Ray-in is throttled in two cases: a hit ray when ray-out is stalled, and a miss ray when its row is full, or when it matches no row and no row is free. The fill-return port has no back-pressure and is sampled whenever its valid is high. The error flag is a plain level.

Top module: `ray_miss_accum`

## Requirements
- R1: A ray presented with its hit bit set (in_hit = 1) appears on ray-out in the same cycle with the same ID. For such a ray, in_ready equals out_ready.
- R2: A miss whose address matches no row that is awaiting its data allocates a free row. It then raises req_valid with that address, and holds req_valid and req_addr steady until req_ready is seen.
- R3: A miss whose address matches a row that is awaiting its data is added to that row and creates no further request. Each address yields exactly one request handshake.
- R4: A miss ray is refused (in_ready = 0) when its matching row already holds 8 rays, or when it matches no row and all 4 rows are occupied.
- R5: After a fill whose address matches a waiting row, that row presents its rays on ray-out starting the next cycle. It releases one per accepted cycle, in arrival order. A miss that joins the row in the same cycle as the fill is released after the earlier rays.
- R6: A hit ray wins ray-out over a draining row. The drain resumes with the same ray once the hit has gone.
- R7: A row becomes free after its last ray leaves, and can then take a miss on a new address.
- R8: A fill whose address matches no waiting row changes no row and releases no ray. It sets fill_err, which stays at 1 until reset.
- R9: After reset, out_valid, req_valid and fill_err are 0.
- R10: When several rows are draining at once, the lowest-numbered row is released first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ray-in valid |
| in_ready | output | 1 | Ray-in ready |
| in_id | input | 8 | Incoming ray ID |
| in_hit | input | 1 | 1 = the ray hit in the cache |
| in_addr | input | 16 | Block address the ray touched |
| out_valid | output | 1 | Ray-out valid |
| out_ready | input | 1 | Ray-out ready from the pipeline |
| out_id | output | 8 | Outgoing ray ID |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request ready |
| req_addr | output | 16 | Block address to fetch |
| fill_valid | input | 1 | Fill return strobe |
| fill_addr | input | 16 | Address of the returned block |
| fill_err | output | 1 | Sticky flag for a fill that matched no row |

## Verification
Two collisions matter for this block. The first is a fill that lands in the same cycle as a new miss on the same address. The bench drives both ports on one edge and expects both parked rays back, with the earlier ray first and no second request. The second is a hit ray that arrives while a row is draining. The bench holds a hit on ray-in during a drain, expects the hit's ID on ray-out, and then expects the drain to resume with the ray it had been showing.

// File: rtl/rma_pkg.sv
package rma_pkg;
  typedef enum logic [1:0] {
    ROW_FREE  = 2'd0,
    ROW_PEND  = 2'd1,
    ROW_WAIT  = 2'd2,
    ROW_DRAIN = 2'd3
  } row_st_e;
endpackage

// File: rtl/rma_pick.sv
// Lowest-index picker: one-hot grant plus its binary index.
module rma_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rma_row.sv
// One parking row: tag, state, FIFO of ray IDs.
module rma_row
  import rma_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ID_W   = 8,
  parameter int ADDR_W = 16,
  localparam int PW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              alloc_i,
  input  logic              append_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              fill_i,
  input  logic              req_done_i,
  input  logic              pop_i,
  output row_st_e           st_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic              miss_match_o,
  output logic              fill_match_o,
  output logic              full_o,
  output logic [ID_W-1:0]   head_id_o
);
  row_st_e           st;
  logic [ADDR_W-1:0] tag;
  logic [CW-1:0]     cnt;
  logic [PW-1:0]     head;
  logic [ID_W-1:0]   slot [SLOTS];
  logic              waiting;
  logic              last_pop;

  assign waiting      = (st == ROW_PEND) || (st == ROW_WAIT);
  assign miss_match_o = waiting && (tag == miss_addr);
  assign fill_match_o = waiting && (tag == fill_addr);
  assign full_o       = (cnt == CW'(SLOTS));
  assign head_id_o    = slot[head];
  assign st_o         = st;
  assign tag_o        = tag;
  assign last_pop     = (CW'({1'b0, head}) + CW'(1)) == cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ROW_FREE;
      tag  <= '0;
      cnt  <= '0;
      head <= '0;
    end else begin
      if (alloc_i) begin
        st      <= ROW_PEND;
        tag     <= miss_addr;
        cnt     <= CW'(1);
        head    <= '0;
        slot[0] <= id_i;
      end else if (append_i) begin
        slot[cnt[PW-1:0]] <= id_i;
        cnt <= cnt + CW'(1);
      end
      if (fill_i) begin
        st <= ROW_DRAIN;
      end else if (req_done_i && st == ROW_PEND) begin
        st <= ROW_WAIT;
      end
      if (pop_i) begin
        if (last_pop) begin
          st   <= ROW_FREE;
          cnt  <= '0;
          head <= '0;
        end else begin
          head <= head + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ray_miss_accum.sv
module ray_miss_accum
  import rma_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int SLOTS  = 8,
  parameter int ID_W   = 8,
  parameter int ADDR_W = 16,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic              in_hit,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              fill_err
);
  row_st_e           st    [ROWS];
  logic [ADDR_W-1:0] tag   [ROWS];
  logic [ID_W-1:0]   hid   [ROWS];
  logic [ROWS-1:0]   miss_m, fill_m, full_v, free_v, drain_v, pend_v;
  logic [ROWS-1:0]   alloc_v, append_v, fill_v, done_v, pop_v;
  logic [ROWS-1:0]   free_oh, drain_oh, pend_oh, match_oh;
  logic [RW-1:0]     free_idx, drain_idx, pend_idx, match_idx, sel_idx;
  logic              hit_in, miss_fire, any_match, lock_vld;
  logic [RW-1:0]     lock_idx;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    rma_row #(.SLOTS(SLOTS), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_row (
      .clk(clk), .rst_n(rst_n),
      .miss_addr(in_addr), .fill_addr(fill_addr),
      .alloc_i(alloc_v[g]), .append_i(append_v[g]), .id_i(in_id),
      .fill_i(fill_v[g]), .req_done_i(done_v[g]), .pop_i(pop_v[g]),
      .st_o(st[g]), .tag_o(tag[g]),
      .miss_match_o(miss_m[g]), .fill_match_o(fill_m[g]),
      .full_o(full_v[g]), .head_id_o(hid[g])
    );
    assign free_v[g]  = (st[g] == ROW_FREE);
    assign drain_v[g] = (st[g] == ROW_DRAIN);
    assign pend_v[g]  = (st[g] == ROW_PEND);
  end

  rma_pick #(.N(ROWS)) u_pick_free  (.req(free_v),  .gnt(free_oh),  .idx(free_idx));
  rma_pick #(.N(ROWS)) u_pick_drain (.req(drain_v), .gnt(drain_oh), .idx(drain_idx));
  rma_pick #(.N(ROWS)) u_pick_pend  (.req(pend_v),  .gnt(pend_oh),  .idx(pend_idx));
  rma_pick #(.N(ROWS)) u_pick_match (.req(miss_m),  .gnt(match_oh), .idx(match_idx));

  // Ray-in acceptance
  assign hit_in    = in_valid && in_hit;
  assign any_match = |miss_m;
  always_comb begin
    if (in_hit)         in_ready = out_ready;
    else if (any_match) in_ready = !full_v[match_idx];
    else                in_ready = |free_v;
  end
  assign miss_fire = in_valid && !in_hit && in_ready;
  assign append_v  = miss_fire ? match_oh : '0;
  assign alloc_v   = (miss_fire && !any_match) ? free_oh : '0;

  // Ray-out: hit first, then lowest draining row
  assign out_valid = hit_in || (|drain_v);
  assign out_id    = hit_in ? in_id : hid[drain_idx];
  assign pop_v     = (out_ready && !hit_in) ? drain_oh : '0;

  // Memory requests, locked to one row while stalled
  assign sel_idx   = (lock_vld && pend_v[lock_idx]) ? lock_idx : pend_idx;
  assign req_valid = |pend_v;
  assign req_addr  = tag[sel_idx];
  for (genvar g = 0; g < ROWS; g++) begin : g_done
    assign done_v[g] = req_valid && req_ready && (sel_idx == RW'(g));
  end

  // Fill return
  assign fill_v = fill_valid ? fill_m : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_vld <= 1'b0;
      lock_idx <= '0;
      fill_err <= 1'b0;
    end else begin
      lock_vld <= req_valid && !req_ready;
      lock_idx <= sel_idx;
      if (fill_valid && !(|fill_m)) fill_err <= 1'b1;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{free_idx, pend_oh, drain_idx};
endmodule

// File: rtl/ray_miss_accum_chk.sv
module ray_miss_accum_chk #(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ID_W-1:0]   in_id,
  input logic              in_hit,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ID_W-1:0]   out_id,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              fill_valid,
  input logic              fill_err
);
  AST_HIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_hit |-> out_valid && out_id == in_id); // R1
  AST_HIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_hit |-> in_ready == out_ready); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !fill_valid |=> req_valid && $stable(req_addr)); // R2
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !(in_valid && in_hit) |=> out_valid); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |=> fill_err); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_err) |-> $past(fill_valid)); // R8
endmodule

bind ray_miss_accum ray_miss_accum_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ray_miss_accum.sv
module tb_ray_miss_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_hit = 1'b0, out_ready = 1'b1;
  logic        req_ready = 1'b0, fill_valid = 1'b0;
  logic [7:0]  in_id = '0;
  logic [15:0] in_addr = '0, fill_addr = '0;
  logic        in_ready, out_valid, req_valid, fill_err;
  logic [7:0]  out_id;
  logic [15:0] req_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ray_miss_accum dut (.*);

  // {out_ready, id}
  localparam logic [8:0] HIT_VEC [6] = '{
    9'h105, 9'h0A7, 9'h1FF, 9'h000, 9'h133, 9'h05C
  };

  localparam logic [15:0] A = 16'h0100, B = 16'h0220, C = 16'h0340,
                          D = 16'h0460, E = 16'h0580, F = 16'h06A0,
                          G = 16'h07C0, H = 16'h08E0, Z = 16'h0BAD;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    in_valid = 1'b0; fill_valid = 1'b0; req_ready = 1'b0; in_hit = 1'b0;
  endtask

  task automatic send_miss(input logic [7:0] id, input logic [15:0] a);
    @(negedge clk); quiet();
    in_valid = 1'b1; in_id = id; in_addr = a;
    #1 chk(in_ready == 1'b1, "R4 miss accepted", in_ready, 1);
    @(posedge clk);
  endtask

  task automatic do_req(input logic [15:0] a);
    @(negedge clk); quiet();
    req_ready = 1'b1;
    #1 chk(req_valid && req_addr == a, "R2 request address", req_addr, a);
    @(posedge clk);
  endtask

  task automatic fill(input logic [15:0] a);
    @(negedge clk); quiet();
    fill_valid = 1'b1; fill_addr = a;
    @(posedge clk);
  endtask

  task automatic expect_out(input logic [7:0] id, input string req);
    @(negedge clk); quiet();
    out_ready = 1'b1;
    #1 chk(out_valid && out_id == id, req, out_id, id);
    @(posedge clk);
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk); quiet();
    #1 chk(!out_valid, req, out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk(!out_valid && !req_valid && !fill_err, "R9 reset outputs",
           {out_valid, req_valid, fill_err}, 0);
    rst_n = 1'b1;

    // Hit pass-through table (R1)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_hit = 1'b1; in_id = HIT_VEC[i][7:0];
      out_ready = HIT_VEC[i][8];
      #1 chk(out_valid && out_id == HIT_VEC[i][7:0], "R1 hit id", out_id, HIT_VEC[i][7:0]);
      chk(in_ready == HIT_VEC[i][8], "R1 hit ready", in_ready, HIT_VEC[i][8]);
      @(posedge clk);
    end
    @(negedge clk); quiet(); out_ready = 1'b1;

    // One request for three misses on A, drained in order
    send_miss(8'd10, A); send_miss(8'd11, A); send_miss(8'd12, A);
    do_req(A);
    @(negedge clk); quiet();
    #1 chk(!req_valid, "R3 single request for A", req_valid, 0);
    fill(A);
    expect_out(8'd10, "R5 drain order 0");
    expect_out(8'd11, "R5 drain order 1");
    expect_out(8'd12, "R5 drain order 2");
    expect_idle("R7 row A empty");

    // Hit overrides a draining row
    send_miss(8'd20, B); do_req(B); fill(B);
    @(negedge clk); quiet();
    in_valid = 1'b1; in_hit = 1'b1; in_id = 8'd99;
    #1 chk(out_valid && out_id == 8'd99, "R6 hit wins", out_id, 99);
    @(posedge clk);
    expect_out(8'd20, "R6 drain resumes");
    expect_idle("R7 row B empty");

    // Full row and no free row
    for (int k = 0; k < 8; k++) send_miss(8'(30 + k), C);
    @(negedge clk); quiet();
    in_valid = 1'b1; in_id = 8'd38; in_addr = C;
    #1 chk(!in_ready, "R4 full row refuses", in_ready, 0);
    send_miss(8'd40, D); send_miss(8'd41, E); send_miss(8'd42, F);
    @(negedge clk); quiet();
    in_valid = 1'b1; in_id = 8'd43; in_addr = G;
    #1 chk(!in_ready, "R4 no free row refuses", in_ready, 0);
    do_req(C); do_req(D); do_req(E); do_req(F);
    @(negedge clk); quiet();
    #1 chk(!req_valid, "R3 one request per address", req_valid, 0);

    fill(C);
    for (int k = 0; k < 8; k++) expect_out(8'(30 + k), "R5 drain full row");
    send_miss(8'd43, G);   // R7: freed row reused
    do_req(G);

    // Unmatched fill
    fill(Z);
    expect_idle("R8 no release on stray fill");
    chk(fill_err, "R8 error set", fill_err, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fill_err, "R8 error sticky", fill_err, 1);

    // Several rows draining
    fill(D);
    expect_out(8'd40, "R5 row D");
    @(negedge clk); quiet(); out_ready = 1'b0;
    fill(F); fill(E);
    expect_out(8'd41, "R10 lower row first");
    expect_out(8'd42, "R10 higher row next");

    // Fill and append in the same cycle
    send_miss(8'd50, H); do_req(H);
    @(negedge clk); quiet();
    in_valid = 1'b1; in_id = 8'd51; in_addr = H;
    fill_valid = 1'b1; fill_addr = H;
    #1 chk(in_ready, "R5 append with fill accepted", in_ready, 1);
    @(posedge clk);
    expect_out(8'd50, "R5 earlier ray first");
    expect_out(8'd51, "R5 same-cycle append released");
    expect_idle("R7 row H empty");
    @(negedge clk);
    chk(!req_valid, "R3 no request from same-cycle append", req_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule